// File: doc/BRIEF.md
# System Control Register Block

This block is a memory-mapped register file sitting on a zero-wait-state 32-bit peripheral bus, occupying a 4 KB window. The window is covered by an array of 32-bit words, one per word-aligned byte offset. Software uses most of the window as plain read/write storage. A few words come up holding fixed identification values after reset.

One word acts as a command register. Writing particular codes to it produces a single-cycle request pulse, either for a system reset or for a power-off. The logic that acts on these pulses lies outside the block. Three status words always read back with bits 29 and 28 set, whatever value is stored in them.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, offset 0x100 reads 0x35F20121, 0x104 reads 0x00000002, 0x108 reads 0x35F30121 and 0x10C reads 0x35F40121. The stored reset values are 0x05F20121, 0x00000002, 0x05F30121 and 0x05F40121, and reads of the status words add bits 29:28.
- R2: After reset, every other word reads zero.
- R3: A write (psel, penable and pwrite high at a rising clock edge) stores pwdata in word paddr[11:2]. This includes the command word at offset 0xF00, which reads back its last written value.
- R4: A write of 1 or 2 to offset 0xF00 drives reset_req high for the single clock cycle that follows the write edge.
- R5: A write of 3 to offset 0xF00 drives shutdown_req high for the single clock cycle that follows the write edge.
- R6: A write of any other value to 0xF00, or a write to any other offset, raises neither request.
- R7: A read of offset 0x100, 0x108 or 0x10C returns the stored word with bits 29 and 28 forced to 1, and the stored bits are left unchanged. Offset 0x104 is not forced.
- R8: Address bits 1:0 are ignored, so offsets 0x202 and 0x200 select the same word.
- R9: pready is always high.
- R10: reset_req and shutdown_req are never high in the same cycle, and neither stays high for two consecutive cycles when the writes follow the two-phase bus protocol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Select |
| penable | input | 1 | Access phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always high |
| reset_req | output | 1 | One-cycle system reset request |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
The bench builds the block with its default parameters: a 12-bit address, 32-bit data and the command word at 0xF00. With these values the whole 4 KB window can be reached, including the command word at the top. The status words and the ID reset values all sit at their decode offsets. The tests cover the three request codes and a neighbouring non-request code, status-word forcing on a stored zero, and aliasing of the low address bits.

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter logic [ADDR_W-1:0] CMD_OFS = 12'hF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              reset_req,
  output logic              shutdown_req
);
  localparam int WORDS = 2 ** (ADDR_W - 2);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] CMD_IDX = CMD_OFS[ADDR_W-1:2];
  localparam logic [IDX_W-1:0] ST0 = IDX_W'(32'h40);
  localparam logic [IDX_W-1:0] ST1 = IDX_W'(32'h41);
  localparam logic [IDX_W-1:0] ST2 = IDX_W'(32'h42);
  localparam logic [IDX_W-1:0] ST3 = IDX_W'(32'h43);
  localparam logic [DATA_W-1:0] FORCE_MASK = DATA_W'(32'h3000_0000);

  logic [DATA_W-1:0] mem [WORDS];
  logic [IDX_W-1:0]  idx;
  logic              wr, is_cmd, forced;
  logic [1:0]        unused_low;

  assign unused_low = paddr[1:0];
  assign idx    = paddr[ADDR_W-1:2];
  assign wr     = psel & penable & pwrite;
  assign is_cmd = idx == CMD_IDX;
  assign forced = (idx == ST0) | (idx == ST2) | (idx == ST3);
  assign prdata = mem[idx] | (forced ? FORCE_MASK : '0);
  assign pready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      mem[ST0] <= DATA_W'(32'h05F2_0121);
      mem[ST1] <= DATA_W'(32'h0000_0002);
      mem[ST2] <= DATA_W'(32'h05F3_0121);
      mem[ST3] <= DATA_W'(32'h05F4_0121);
    end else if (wr) begin
      mem[idx] <= pwdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_req    <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      reset_req    <= wr & is_cmd & (pwdata == DATA_W'(1) || pwdata == DATA_W'(2));
      shutdown_req <= wr & is_cmd & (pwdata == DATA_W'(3));
    end
  end

  AST_RST_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && paddr[ADDR_W-1:2] == CMD_IDX && (pwdata == 1 || pwdata == 2)) |=> reset_req); // R4
  AST_OFF_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && paddr[ADDR_W-1:2] == CMD_IDX && pwdata == 3) |=> shutdown_req); // R5
  AST_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable && pwrite && paddr[ADDR_W-1:2] == CMD_IDX) |=> (!reset_req && !shutdown_req)); // R6
  AST_FORCED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (paddr[ADDR_W-1:2] == ST0 || paddr[ADDR_W-1:2] == ST2 || paddr[ADDR_W-1:2] == ST3) |-> prdata[29:28] == 2'b11); // R7
  AST_READY: assert property (@(posedge clk) disable iff (!rst_n) pready); // R9
  AST_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({reset_req, shutdown_req})); // R10
endmodule

// File: tb/sim_sysctl_regs.sv
`timescale 1ns/1ps
module sim_sysctl_regs;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, reset_req, shutdown_req;
  int checks = 0, errors = 0;
  logic rr1, sr1, rr2, sr2;
  bit done = 0;

  always #5 clk = ~clk;

  sysctl_regs u0 (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
                  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
                  .reset_req(reset_req), .shutdown_req(shutdown_req));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); rr1 = reset_req; sr1 = shutdown_req; psel = 0; penable = 0; pwrite = 0;
    @(negedge clk); rr2 = reset_req; sr2 = shutdown_req;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic t_reset_values();
    logic [31:0] d;
    rd(12'h100, d); chk("R1", d, 32'h35F20121);
    rd(12'h104, d); chk("R1", d, 32'h00000002);
    rd(12'h108, d); chk("R1", d, 32'h35F30121);
    rd(12'h10C, d); chk("R1", d, 32'h35F40121);
    rd(12'h000, d); chk("R2", d, 0);
    rd(12'hF00, d); chk("R2", d, 0);
    rd(12'hFFC, d); chk("R2", d, 0);
    chk("R9", {31'b0, pready}, 1);
  endtask

  task automatic t_storage();
    logic [31:0] d;
    wr(12'h010, 32'hDEADBEEF); rd(12'h010, d); chk("R3", d, 32'hDEADBEEF);
    wr(12'h7F8, 32'h12345678); rd(12'h7F8, d); chk("R3", d, 32'h12345678);
    chk("R6", {30'b0, rr1, sr1}, 0);
    wr(12'h202, 32'hA5A5A5A5); rd(12'h200, d); chk("R8", d, 32'hA5A5A5A5);
    rd(12'h201, d); chk("R8", d, 32'hA5A5A5A5);
  endtask

  task automatic t_requests();
    logic [31:0] d;
    wr(12'hF00, 1);
    chk("R4", {30'b0, rr1, sr1}, 2'b10); chk("R10", {30'b0, rr2, sr2}, 0);
    wr(12'hF00, 2);
    chk("R4", {30'b0, rr1, sr1}, 2'b10); chk("R10", {30'b0, rr2, sr2}, 0);
    rd(12'hF00, d); chk("R3", d, 2);
    wr(12'hF00, 3);
    chk("R5", {30'b0, rr1, sr1}, 2'b01); chk("R10", {30'b0, rr2, sr2}, 0);
    rd(12'hF00, d); chk("R3", d, 3);
    wr(12'hF00, 4); chk("R6", {30'b0, rr1, sr1}, 0);
    wr(12'hF00, 0); chk("R6", {30'b0, rr1, sr1}, 0);
    wr(12'hF04, 1); chk("R6", {30'b0, rr1, sr1}, 0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    wr(12'h100, 0); rd(12'h100, d); chk("R7", d, 32'h30000000);
    wr(12'h108, 32'hFFFF_0000); rd(12'h108, d); chk("R7", d, 32'hFFFF_0000);
    wr(12'h10C, 32'h0000_0001); rd(12'h10C, d); chk("R7", d, 32'h3000_0001);
    wr(12'h104, 0); rd(12'h104, d); chk("R7", d, 0);
    rd(12'h110, d); chk("R7", d, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #10000000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_values();
    t_storage();
    t_requests();
    t_status();
    finish_run();
  end
endmodule